// File: doc/BRIEF.md
# Discrete I/O Controller with Edge Interrupts

The block controls a bank of discrete signal lines, by default sixteen. Each line can be set as an input or an output. Output lines are driven from a data register, and the block's output-enable signals steer the tristate pad buffers outside it. Input lines pass through a two-stage synchronizer. A read of the data register returns the whole bank at once: the synchronized pin value for an input line and the driven value for an output line.

Each line is watched for a transition on the level it currently shows: the synchronized pin value for an input, the driven value for an output. A per-line select bit chooses whether a rising or a falling transition counts. An event sets a sticky status bit, and software clears it by writing a one. A status bit reads back as set only while its enable bit is one. Two interrupt outputs, one per CPU, are each qualified by that CPU's own mask register, so the same event sources can be steered to either CPU or to both.

Changing a line's direction or its edge select changes the level being watched, so it can create an event that is latched like a real one. Software is expected to clear such events after any configuration change.

Top module: `dio_edge_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every register reads 0, `pin_oe` is all zero (every line an input) and `irq` is all zero.
- R2: Writing address 1 (direction) sets `pin_oe` to the written value from the next cycle on. A 1 bit makes the line an output and a 0 bit makes it an input.
- R3: Writing address 0 (data) sets `pin_out` from the next cycle on. Reading address 0 returns the driven value on output lines and, on input lines, the pin value as it stood two clock edges earlier.
- R4: Address 2 holds the edge select: a 1 bit selects the rising edge and a 0 bit the falling edge. A matching transition on an input pin sets its status bit on the third clock edge after the pin changes.
- R5: Writing address 4 (status) clears every status bit written as 1 and leaves every bit written as 0 unchanged. Without a write to address 4, no status bit ever clears.
- R6: Reading address 4 returns the status ANDed with the enable register at address 3, so a status bit with its enable bit at 0 reads as 0.
- R7: `irq[n]` is high exactly when some line has status, enable and the CPU n mask (address 5 + n) all at 1. It is a level signal and can fall only after a bus write.
- R8: If an event and a clearing write reach the same status bit on the same clock edge, the bit stays set.
- R9: A write that changes a line's direction or edge select, and so changes the level being watched into the selected edge, sets that line's status bit one edge after the write.
- R10: Addresses 1, 2, 3, 5 and 6 read back the value last written. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | N_LINES | Write data |
| bus_rdata | output | N_LINES | Read data for `bus_addr` (combinational) |
| pin_in | input | N_LINES | Asynchronous pin levels from the pads |
| pin_out | output | N_LINES | Value driven onto the output lines |
| pin_oe | output | N_LINES | Output enable per line, 1 = drive |
| irq | output | N_CPU | Interrupt level, one per CPU |

## Verification
The bench builds the block with its default values, sixteen lines and two CPUs. This leaves room to give the two masks disjoint bits, so that one event source can raise one interrupt without the other. It also lets input and output lines share one data word and makes every address from 0 to 7 reachable. Directed sequences then place a pin transition exactly on the cycle of a clearing write, and flip the direction and edge settings under a held pin to raise the spurious events.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 3'd0,
        REG_DIR   = 3'd1,
        REG_RISE  = 3'd2,
        REG_IEN   = 3'd3,
        REG_STAT  = 3'd4,
        REG_MASK0 = 3'd5
    } reg_sel_e;

    function automatic logic [ADDR_W-1:0] mask_addr(input int cpu);
        return ADDR_W'(int'(REG_MASK0) + cpu);
    endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.meta   = async_in;
        r_d.stable = r_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_out = r_q.stable;
endmodule

// File: rtl/dio_edge_det.sv
module dio_edge_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] evt
);
    // Watched level folded by the edge select: a selected edge is always a 0->1 step.
    logic [W-1:0] armed_d, armed_q;

    always_comb begin
        armed_d = level ^ ~rise_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= '1;
        else        armed_q <= armed_d;
    end

    assign evt = armed_d & ~armed_q;
endmodule

// File: rtl/dio_irq_route.sv
module dio_irq_route #(
    parameter int W     = 16,
    parameter int N_CPU = 2
) (
    input  logic [W-1:0]            pending,
    input  logic [N_CPU-1:0][W-1:0] mask,
    output logic [N_CPU-1:0]        irq
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        assign irq[c] = |(pending & mask[c]);
    end
endmodule

// File: rtl/dio_edge_ctrl.sv
module dio_edge_ctrl
    import dio_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_CPU   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] pin_out,
    output logic [N_LINES-1:0] pin_oe,
    output logic [N_CPU-1:0]   irq
);
    typedef struct packed {
        logic [N_LINES-1:0]            drive;
        logic [N_LINES-1:0]            dir;
        logic [N_LINES-1:0]            rise;
        logic [N_LINES-1:0]            ien;
        logic [N_LINES-1:0]            stat;
        logic [N_CPU-1:0][N_LINES-1:0] mask;
    } regs_t;

    regs_t              r_d, r_q;
    logic [N_LINES-1:0] pin_sync;
    logic [N_LINES-1:0] watched;
    logic [N_LINES-1:0] evt;
    logic [N_LINES-1:0] clr;

    dio_sync #(.W(N_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    // Output lines watch their own driven value, input lines the synchronized pin.
    assign watched = (r_q.dir & r_q.drive) | (~r_q.dir & pin_sync);

    dio_edge_det #(.W(N_LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (watched),
        .rise_sel (r_q.rise),
        .evt      (evt)
    );

    dio_irq_route #(.W(N_LINES), .N_CPU(N_CPU)) u_route (
        .pending (r_q.stat & r_q.ien),
        .mask    (r_q.mask),
        .irq     (irq)
    );

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (bus_we) begin
            case (bus_addr)
                REG_DATA: r_d.drive = bus_wdata;
                REG_DIR:  r_d.dir   = bus_wdata;
                REG_RISE: r_d.rise  = bus_wdata;
                REG_IEN:  r_d.ien   = bus_wdata;
                REG_STAT: clr       = bus_wdata;
                default: begin
                    for (int c = 0; c < N_CPU; c++) begin
                        if (bus_addr == mask_addr(c)) r_d.mask[c] = bus_wdata;
                    end
                end
            endcase
        end
        // A fresh event wins over a clear on the same edge.
        r_d.stat = (r_q.stat & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA: bus_rdata = watched;
            REG_DIR:  bus_rdata = r_q.dir;
            REG_RISE: bus_rdata = r_q.rise;
            REG_IEN:  bus_rdata = r_q.ien;
            REG_STAT: bus_rdata = r_q.stat & r_q.ien;
            default: begin
                for (int c = 0; c < N_CPU; c++) begin
                    if (bus_addr == mask_addr(c)) bus_rdata = r_q.mask[c];
                end
            end
        endcase
    end

    assign pin_out = r_q.drive;
    assign pin_oe  = r_q.dir;
endmodule

// File: rtl/dio_edge_ctrl_chk.sv
module dio_edge_ctrl_chk
    import dio_pkg::*;
#(
    parameter int N_LINES = 16,
    parameter int N_CPU   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [N_LINES-1:0] bus_wdata,
    input logic [N_LINES-1:0] bus_rdata,
    input logic [N_LINES-1:0] pin_oe,
    input logic [N_CPU-1:0]   irq,
    input logic [N_LINES-1:0] stat,
    input logic [N_LINES-1:0] ien
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && irq == '0));

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R5
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_STAT) |=> ((stat & $past(stat)) == $past(stat)));

    // R6
    stat_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_STAT) |-> ((bus_rdata & ~ien) == '0));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((irq & $past(irq)) == $past(irq)));
endmodule

bind dio_edge_ctrl dio_edge_ctrl_chk #(.N_LINES(N_LINES), .N_CPU(N_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .stat      (r_q.stat),
    .ien       (r_q.ien)
);

// File: tb/dio_edge_ctrl_bench.sv
module dio_edge_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [NL-1:0] bus_wdata = '0;
    logic [NL-1:0] bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic [1:0]    irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_edge_ctrl u_dio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Reference model state
    bit [NL-1:0] m_drive, m_dir, m_rise, m_ien, m_stat;
    bit [NL-1:0] m_mask [2];
    bit [NL-1:0] hist [$];
    bit          m_prev [NL];

    task automatic model_reset();
        m_drive = '0; m_dir = '0; m_rise = '0; m_ien = '0; m_stat = '0;
        m_mask[0] = '0; m_mask[1] = '0;
        hist = '{16'h0, 16'h0};
        for (int i = 0; i < NL; i++) m_prev[i] = 1'b1;
    endtask

    task automatic model_step();
        bit [NL-1:0] ev;
        bit [NL-1:0] wipe;
        if (!rst_n) begin
            model_reset();
            return;
        end
        ev = '0;
        for (int i = 0; i < NL; i++) begin
            bit lvl;
            bit hit;
            lvl = m_dir[i] ? m_drive[i] : hist[0][i];
            hit = m_rise[i] ? lvl : !lvl;
            ev[i] = hit && !m_prev[i];
            m_prev[i] = hit;
        end
        wipe = (bus_we && bus_addr == 3'd4) ? bus_wdata : '0;
        m_stat = (m_stat & ~wipe) | ev;
        if (bus_we) begin
            case (bus_addr)
                3'd0: m_drive = bus_wdata;
                3'd1: m_dir = bus_wdata;
                3'd2: m_rise = bus_wdata;
                3'd3: m_ien = bus_wdata;
                3'd5: m_mask[0] = bus_wdata;
                3'd6: m_mask[1] = bus_wdata;
                default: ;
            endcase
        end
        hist.push_back(pin_in);
        while (hist.size() > 2) void'(hist.pop_front());
    endtask

    function automatic bit [NL-1:0] model_read(input bit [2:0] a);
        case (a)
            3'd0: return (m_dir & m_drive) | (~m_dir & hist[0]);
            3'd1: return m_dir;
            3'd2: return m_rise;
            3'd3: return m_ien;
            3'd4: return m_stat & m_ien;
            3'd5: return m_mask[0];
            3'd6: return m_mask[1];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic compare();
        bit [1:0] exp_irq;
        string rq;
        for (int c = 0; c < 2; c++) exp_irq[c] = |(m_stat & m_ien & m_mask[c]);
        chk("R2 pin_oe", pin_oe, m_dir);
        chk("R3 pin_out", pin_out, m_drive);
        chk("R7 irq", {14'd0, irq}, {14'd0, exp_irq});
        case (bus_addr)
            3'd0: rq = "R3 data read";
            3'd4: rq = "R6 status read";
            default: rq = "R10 register read";
        endcase
        chk(rq, bus_rdata, model_read(bus_addr));
    endtask

    task automatic cyc(input bit we, input bit [2:0] addr, input bit [NL-1:0] wdata);
        bus_we = we; bus_addr = addr; bus_wdata = wdata;
        @(posedge clk);
        model_step();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic rd(input bit [2:0] addr);
        cyc(1'b0, addr, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst_n = 1'b0;
        @(negedge clk);
        cyc(1'b0, 3'd0, '0);
        cyc(1'b0, 3'd0, '0);
        // R1: reset state on every address while in reset
        for (int a = 0; a < 8; a++) begin
            rd(3'(a));
            chk("R1 reset read", bus_rdata, '0);
        end
        chk("R1 reset oe", pin_oe, '0);
        rst_n = 1'b1;
        rd(3'd4);
        chk("R1 irq after reset", {14'd0, irq}, '0);

        // R2 / R3: lower byte outputs, upper byte inputs
        cyc(1'b1, 3'd1, 16'h00FF);
        chk("R2 oe after dir write", pin_oe, 16'h00FF);
        cyc(1'b1, 3'd0, 16'hA5A5);
        chk("R3 drive value", pin_out, 16'hA5A5);
        pin_in = 16'h3C00;
        rd(3'd0);
        rd(3'd0);
        chk("R3 mixed read", bus_rdata, 16'h3CA5);

        // R10 configuration readback
        cyc(1'b1, 3'd2, 16'h0100);
        cyc(1'b1, 3'd3, 16'hFFFF);
        cyc(1'b1, 3'd5, 16'h0100);
        cyc(1'b1, 3'd6, 16'h0E00);
        rd(3'd5); chk("R10 mask0 readback", bus_rdata, 16'h0100);
        rd(3'd6); chk("R10 mask1 readback", bus_rdata, 16'h0E00);
        rd(3'd7); chk("R10 unused address", bus_rdata, 16'h0000);
        cyc(1'b1, 3'd4, 16'hFFFF);

        // R4: rising on line 8, status on the third edge
        pin_in = 16'h3D00;
        rd(3'd4);
        rd(3'd4);
        chk("R4 not yet latched", bus_rdata & 16'h0100, 16'h0000);
        rd(3'd4);
        chk("R4 rising latched", bus_rdata & 16'h0100, 16'h0100);
        chk("R7 irq0 from line 8", {14'd0, irq}, 16'h0001);

        // R4: falling on line 9
        pin_in = 16'h3F00;
        repeat (3) rd(3'd4);
        chk("R4 rising ignored on falling line", bus_rdata & 16'h0200, 16'h0000);
        pin_in = 16'h3D00;
        repeat (3) rd(3'd4);
        chk("R4 falling latched", bus_rdata & 16'h0200, 16'h0200);
        chk("R7 both irqs", {14'd0, irq}, 16'h0003);

        // R5: zeros ignored, ones clear
        cyc(1'b1, 3'd4, 16'h0000);
        rd(3'd4);
        chk("R5 zero write keeps", bus_rdata & 16'h0300, 16'h0300);
        cyc(1'b1, 3'd4, 16'h0100);
        rd(3'd4);
        chk("R5 one write clears", bus_rdata & 16'h0300, 16'h0200);
        chk("R7 irq0 dropped", {14'd0, irq}, 16'h0002);

        // R6: enable gates visibility only
        cyc(1'b1, 3'd3, 16'hFDFF);
        rd(3'd4);
        chk("R6 disabled bit hidden", bus_rdata & 16'h0200, 16'h0000);
        cyc(1'b1, 3'd3, 16'hFFFF);
        rd(3'd4);
        chk("R6 bit still held", bus_rdata & 16'h0200, 16'h0200);
        cyc(1'b1, 3'd4, 16'hFFFF);

        // R8: falling on line 10 meets a clear on the same edge
        pin_in = 16'h3900;
        rd(3'd4);
        rd(3'd4);
        cyc(1'b1, 3'd4, 16'h0400);
        rd(3'd4);
        chk("R8 event beats clear", bus_rdata & 16'h0400, 16'h0400);
        cyc(1'b1, 3'd4, 16'h0400);
        rd(3'd4);
        chk("R8 later clear works", bus_rdata & 16'h0400, 16'h0000);

        // R9: edge flip on line 11 (pin high) and direction flip on line 0
        cyc(1'b1, 3'd2, 16'h0900);
        rd(3'd4);
        chk("R9 edge change event", bus_rdata & 16'h0800, 16'h0800);
        cyc(1'b1, 3'd1, 16'h00FE);
        rd(3'd4);
        chk("R9 direction change event", bus_rdata & 16'h0001, 16'h0001);

        // R1: reset again mid-run
        rst_n = 1'b0;
        rd(3'd4);
        chk("R1 reset clears irq", {14'd0, irq}, 16'h0000);
        chk("R1 reset clears oe", pin_oe, 16'h0000);
        rst_n = 1'b1;
        rd(3'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule